// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Controller

This block holds a two-bit state for each of `NSRC` interrupt sources and decides when a source may send a notification to the downstream router. Bit 1 (P) means a notification has gone out and no end-of-interrupt has arrived yet. Bit 0 (Q) means another trigger came in while P was set. The value 01 is a masked "off" state. Because triggers that arrive while P is set fold into Q, no source ever has more than one notification outstanding.

Software reaches the state through a memory-mapped window. Each source owns a page of `2^SHIFT` bytes, starting at `srcno << SHIFT`. With `SHIFT` set to 13 or 17, the lower half-page is for triggers and the upper half-page, at `2^(SHIFT-1)`, is for management. With `SHIFT` set to 12 or 16, a single page does both jobs. In the management region the address selects the operation and the write data is ignored. Each recognised load returns the state held before the operation, and the read and the update happen in the same clock edge.

Sources flagged in `LEVEL_MAP` are level-type. Each keeps an asserted bit that follows its `level_in` line. A rising line triggers the source, and an end-of-interrupt that leaves a still-asserted source at 00 sends it out again. Notifications leave on a strobe that carries the source number, at most one per cycle, lowest pending source number first.

Top module: `pq_source_ctrl`

## Requirements
- R1: After reset every source reads as state 00, and no notification is raised until a source is triggered.
- R2: A trigger moves 00 to 10 and raises one notification for that source. It moves 10 to 11 and leaves 11 and 01 unchanged, with no notification in any of these three cases.
- R3: A load at management offset 0x000 is an end-of-interrupt. It moves 10 to 00, moves 11 to 10 and notifies again, and leaves 01 and 00 unchanged. It returns the prior state.
- R4: A load at 0x800 returns the state without changing it. Loads at 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11, raise no notification, and return the prior state. The response data is the prior state in bits 1:0 with zeros above, and it is valid in the cycle after the load request. Writes produce no response.
- R5: A store at management offset 0x400 acts as an end-of-interrupt when `STORE_EOI` is 1. When `STORE_EOI` is 0 it has no effect.
- R6: In two-page mode, any write to the lower half-page triggers the source. The management offsets are decoded in the upper half-page. A load from the lower half-page returns all ones and has no effect.
- R7: In one-page mode, a store at page offset 0x000 triggers the source, and the management loads are decoded in the same page.
- R8: A load at any other offset, any access to a source number at or above `NSRC`, and any store to a load-only offset returns all ones for loads and changes no state.
- R9: A level source triggers when its line rises, using the trigger rule of R2. A falling line only clears the asserted bit. `level_in` of an edge source has no effect.
- R10: An end-of-interrupt on a level source whose line is still high, and which would otherwise return to 00, leaves the source at 10 and notifies again.
- R11: At most one notification is presented per cycle. The notified source number is below `NSRC`, and that source has P set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_in | input | NSRC | Line level of each source, used only for level sources |
| req_valid | input | 1 | Window access request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | SHIFT+clog2(NSRC)+1 | Byte address in the window |
| rsp_valid | output | 1 | Load response valid, one cycle after the request |
| rsp_data | output | 64 | Prior state, or all ones |
| notify_valid | output | 1 | Notification strobe |
| notify_src | output | clog2(NSRC) | Number of the notified source |

## Verification
The assertions check four things on every cycle. A notification only names a source below `NSRC` that holds P. The state of every source stays put while no access arrives and no level line moves. A response follows every load and no store. Reset leaves every source at 00. The exact transition tables for trigger, end-of-interrupt and set cannot be checked that way, nor can the atomic return of the prior state, the offset decode in both page layouts, the store-EOI enable, or the level re-notify. Those are shown only by the bench's scenarios, which compare every response and every notification against an ordered list of expected values.

// File: rtl/pq_source_ctrl.sv
module pq_source_ctrl #(
  parameter int NSRC = 8,
  parameter int SHIFT = 13,
  parameter bit STORE_EOI = 1'b1,
  parameter logic [NSRC-1:0] LEVEL_MAP = 8'h80
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NSRC-1:0]                      level_in,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [SHIFT+$clog2(NSRC):0]          req_addr,
  output logic                                 rsp_valid,
  output logic [63:0]                          rsp_data,
  output logic                                 notify_valid,
  output logic [$clog2(NSRC)-1:0]              notify_src
);
  localparam int ID_W = $clog2(NSRC);
  localparam int SRC_W = ID_W + 1;
  localparam int ADDR_W = SHIFT + SRC_W;
  localparam bit TWO_PAGE = (SHIFT == 13) || (SHIFT == 17);
  localparam int MG_W = TWO_PAGE ? SHIFT - 1 : SHIFT;

  logic [NSRC-1:0][1:0] pq_q, pq_n;
  logic [NSRC-1:0]      asserted_q, nreq_q, set_ntf, p_next;

  wire [SRC_W-1:0] a_src   = req_addr[ADDR_W-1:SHIFT];
  wire [ID_W-1:0]  a_idx   = a_src[ID_W-1:0];
  wire             in_rng  = 32'(a_src) < NSRC;
  wire [SHIFT-1:0] a_off   = req_addr[SHIFT-1:0];
  wire             upper   = a_off[SHIFT-1];
  wire             mg_half = TWO_PAGE ? upper : 1'b1;
  wire [MG_W-1:0]  m_off   = a_off[MG_W-1:0];
  wire             shaped  = ((m_off >> 12) == '0) && (m_off[7:0] == 8'h00);
  wire [3:0]       code    = m_off[11:8];

  wire wr = req_valid & req_write & in_rng;
  wire rd = req_valid & ~req_write & in_rng;

  wire do_trig = wr & (TWO_PAGE ? ~upper : (shaped && code == 4'h0));
  wire do_seoi = wr & mg_half & shaped & (code == 4'h4) & STORE_EOI;
  wire rd_ok   = rd & mg_half & shaped & (code == 4'h0 || code == 4'h8 || code[3:2] == 2'b11);
  wire do_leoi = rd_ok & (code == 4'h0);
  wire do_set  = rd_ok & (code[3:2] == 2'b11);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [1:0] n;
    logic       ntf, hit, rise, hold, eoi_re;
    always_comb begin
      hit  = in_rng && (a_idx == ID_W'(i));
      rise = LEVEL_MAP[i] & level_in[i] & ~asserted_q[i];
      hold = LEVEL_MAP[i] & level_in[i];
      n = pq_q[i];
      ntf = 1'b0;
      eoi_re = 1'b0;
      if (hit && do_set) n = code[1:0];
      if (hit && (do_leoi || do_seoi)) begin
        case (n)
          2'b10: n = 2'b00;
          2'b11: begin n = 2'b10; ntf = 1'b1; eoi_re = 1'b1; end
          default: ;
        endcase
        if (hold && n == 2'b00) begin
          n = 2'b10;
          ntf = 1'b1;
          eoi_re = 1'b1;
        end
      end
      if ((hit && do_trig) || (rise && !eoi_re)) begin
        case (n)
          2'b00: begin n = 2'b10; ntf = 1'b1; end
          2'b10: n = 2'b11;
          default: ;
        endcase
      end
    end
    assign pq_n[i] = n;
    assign set_ntf[i] = ntf;
    assign p_next[i] = n[1];
  end

  assign notify_valid = |nreq_q;
  always_comb begin
    notify_src = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (nreq_q[k]) notify_src = ID_W'(k);
  end
  wire [NSRC-1:0] granted = notify_valid ? (NSRC'(1) << notify_src) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q       <= '0;
      asserted_q <= '0;
      nreq_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      pq_q       <= pq_n;
      asserted_q <= level_in & LEVEL_MAP;
      nreq_q     <= ((nreq_q & ~granted) | set_ntf) & p_next;
      rsp_valid  <= req_valid & ~req_write;
      rsp_data   <= rd_ok ? {62'b0, pq_q[a_idx]} : '1;
    end
  end
endmodule

// File: rtl/pq_source_ctrl_chk.sv
module pq_source_ctrl_chk #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] LEVEL_MAP = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [NSRC-1:0]           level_in,
  input logic                      rsp_valid,
  input logic                      notify_valid,
  input logic [$clog2(NSRC)-1:0]   notify_src,
  input logic [NSRC-1:0][1:0]      pq_q,
  input logic [NSRC-1:0]           asserted_q
);
  AST_NOTIFY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> 32'(notify_src) < NSRC); // R11
  AST_NOTIFY_HAS_P: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> pq_q[notify_src][1]); // R11
  AST_QUIET_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && ((level_in & LEVEL_MAP) == asserted_q)) |=> $stable(pq_q)); // R2
  AST_RSP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pq_q == '0 && !notify_valid)); // R1
endmodule

bind pq_source_ctrl pq_source_ctrl_chk #(.NSRC(NSRC), .LEVEL_MAP(LEVEL_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .level_in(level_in), .rsp_valid(rsp_valid), .notify_valid(notify_valid),
  .notify_src(notify_src), .pq_q(pq_q), .asserted_q(asserted_q));

// File: tb/pq_source_ctrl_bench.sv
module pq_source_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = '1;

  typedef struct { logic [63:0] v; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;

  // two-page instance: 8 sources, source 7 level-type
  logic [7:0]  lvl_a = '0;
  logic        rv_a = 0, rw_a = 0;
  logic [16:0] ra_a = '0;
  logic        rspv_a, nv_a;
  logic [63:0] rspd_a;
  logic [2:0]  ns_a;
  pq_source_ctrl #(.NSRC(8), .SHIFT(13), .STORE_EOI(1'b1), .LEVEL_MAP(8'h80)) u_pq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .level_in(lvl_a), .req_valid(rv_a), .req_write(rw_a),
    .req_addr(ra_a), .rsp_valid(rspv_a), .rsp_data(rspd_a),
    .notify_valid(nv_a), .notify_src(ns_a));

  // one-page instance: 4 sources, store-EOI disabled
  logic [3:0]  lvl_b = '0;
  logic        rv_b = 0, rw_b = 0;
  logic [14:0] ra_b = '0;
  logic        rspv_b, nv_b;
  logic [63:0] rspd_b;
  logic [1:0]  ns_b;
  pq_source_ctrl #(.NSRC(4), .SHIFT(12), .STORE_EOI(1'b0), .LEVEL_MAP(4'h0)) u_pq_source_ctrl_1p (
    .clk(clk), .rst_n(rst_n), .level_in(lvl_b), .req_valid(rv_b), .req_write(rw_b),
    .req_addr(ra_b), .rsp_valid(rspv_b), .rsp_data(rspd_b),
    .notify_valid(nv_b), .notify_src(ns_b));

  exp_t q_rsp_a[$], q_ntf_a[$], q_rsp_b[$], q_ntf_b[$];
  exp_t ea, eb, ec, ed;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) if (rst_n) begin
    if (rspv_a) begin
      if (q_rsp_a.size() == 0) check(0, "unexpected response (2p)", rspd_a, 0);
      else begin ea = q_rsp_a.pop_front(); check(rspd_a == ea.v, ea.tag, rspd_a, ea.v); end
    end
    if (nv_a) begin
      if (q_ntf_a.size() == 0) check(0, "unexpected notify (2p)", 64'(ns_a), 0);
      else begin eb = q_ntf_a.pop_front(); check(64'(ns_a) == eb.v, eb.tag, 64'(ns_a), eb.v); end
    end
    if (rspv_b) begin
      if (q_rsp_b.size() == 0) check(0, "unexpected response (1p)", rspd_b, 0);
      else begin ec = q_rsp_b.pop_front(); check(rspd_b == ec.v, ec.tag, rspd_b, ec.v); end
    end
    if (nv_b) begin
      if (q_ntf_b.size() == 0) check(0, "unexpected notify (1p)", 64'(ns_b), 0);
      else begin ed = q_ntf_b.pop_front(); check(64'(ns_b) == ed.v, ed.tag, 64'(ns_b), ed.v); end
    end
  end

  function automatic logic [16:0] adr_a(input int src, input bit hi, input int off);
    return 17'((src << 13) | (int'(hi) << 12) | off);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc_a(input bit w, input logic [16:0] a);
    @(negedge clk); rv_a = 1; rw_a = w; ra_a = a;
    @(negedge clk); rv_a = 0; rw_a = 0;
    idle(2);
  endtask

  task automatic acc_b(input bit w, input logic [14:0] a);
    @(negedge clk); rv_b = 1; rw_b = w; ra_b = a;
    @(negedge clk); rv_b = 0; rw_b = 0;
    idle(2);
  endtask

  task automatic exp_ntf_a(input int src, input string tag);
    exp_t e; e.v = 64'(src); e.tag = tag; q_ntf_a.push_back(e);
  endtask
  task automatic exp_ntf_b(input int src, input string tag);
    exp_t e; e.v = 64'(src); e.tag = tag; q_ntf_b.push_back(e);
  endtask

  // management load on the two-page instance, expecting value v
  task automatic ld_a(input int src, input int off, input logic [63:0] v, input string tag);
    exp_t e; e.v = v; e.tag = tag; q_rsp_a.push_back(e);
    acc_a(0, adr_a(src, 1, off));
  endtask
  task automatic ld_raw_a(input logic [16:0] a, input logic [63:0] v, input string tag);
    exp_t e; e.v = v; e.tag = tag; q_rsp_a.push_back(e);
    acc_a(0, a);
  endtask
  task automatic ld_b(input int src, input int off, input logic [63:0] v, input string tag);
    exp_t e; e.v = v; e.tag = tag; q_rsp_b.push_back(e);
    acc_b(0, 15'((src << 12) | off));
  endtask

  task automatic finish_run;
    idle(5);
    foreach (q_rsp_a[i]) check(0, {q_rsp_a[i].tag, " missing response"}, 0, q_rsp_a[i].v);
    foreach (q_ntf_a[i]) check(0, {q_ntf_a[i].tag, " missing notify"}, 0, q_ntf_a[i].v);
    foreach (q_rsp_b[i]) check(0, {q_rsp_b[i].tag, " missing response"}, 0, q_rsp_b[i].v);
    foreach (q_ntf_b[i]) check(0, {q_ntf_b[i].tag, " missing notify"}, 0, q_ntf_b[i].v);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    check(!nv_a && !nv_b, "R1 no notify after reset", 64'(nv_a), 0);
    ld_a(0, 'h800, 0, "R1 src0 reset state");
    ld_a(7, 'h800, 0, "R1 src7 reset state");
    ld_b(3, 'h800, 0, "R1 1p src3 reset state");

    // R2 trigger transitions (trigger = write to lower half-page, R6)
    exp_ntf_a(1, "R2 00->10 notify");
    acc_a(1, adr_a(1, 0, 0));
    ld_a(1, 'h800, 2, "R2 state 10 after trigger");
    acc_a(1, adr_a(1, 0, 0));
    ld_a(1, 'h800, 3, "R2 10->11 no notify");
    acc_a(1, adr_a(1, 0, 0));
    ld_a(1, 'h800, 3, "R2 11 holds");
    ld_a(2, 'hD00, 0, "R4 set 01 returns prior 00");
    acc_a(1, adr_a(2, 0, 0));
    ld_a(2, 'h800, 1, "R2 01 holds on trigger");

    // R3 load-EOI
    exp_ntf_a(1, "R3 11 re-notify");
    ld_a(1, 'h000, 3, "R3 EOI returns 11");
    ld_a(1, 'h800, 2, "R3 11->10");
    ld_a(1, 'h000, 2, "R3 EOI returns 10");
    ld_a(1, 'h800, 0, "R3 10->00");
    ld_a(2, 'h000, 1, "R3 EOI on 01 returns 01");
    ld_a(2, 'h800, 1, "R3 01 holds on EOI");
    ld_a(3, 'h000, 0, "R3 EOI on 00");
    ld_a(3, 'h800, 0, "R3 00 holds on EOI");

    // R4 set operations, no notify
    ld_a(3, 'hF00, 0, "R4 set 11 returns 00");
    ld_a(3, 'hE00, 3, "R4 set 10 returns 11");
    ld_a(3, 'hC00, 2, "R4 set 00 returns 10");
    ld_a(3, 'h800, 0, "R4 get after set 00");

    // R5 store-EOI enabled
    exp_ntf_a(4, "R5 trigger src4");
    acc_a(1, adr_a(4, 0, 0));
    acc_a(1, adr_a(4, 1, 'h400));
    ld_a(4, 'h800, 0, "R5 store-EOI cleared 10");

    // R6 two-page layout
    ld_raw_a(adr_a(0, 0, 'h800), ONES, "R6 load in trigger half reads ones");
    ld_a(0, 'h800, 0, "R6 trigger-half load had no effect");
    acc_a(1, adr_a(0, 1, 'h000));
    ld_a(0, 'h800, 0, "R6 store at mgmt 0x000 no trigger");
    exp_ntf_a(0, "R6 any trigger-half write triggers");
    acc_a(1, adr_a(0, 0, 'h800));
    ld_a(0, 'h800, 2, "R6 src0 pending after trigger");

    // R8 unrecognised and out of range
    ld_raw_a(adr_a(8, 1, 'h800), ONES, "R8 source 8 reads ones");
    acc_a(1, adr_a(8, 0, 0));
    ld_a(5, 'h900, ONES, "R8 offset 0x900 reads ones");
    ld_a(5, 'h840, ONES, "R8 offset 0x840 reads ones");
    ld_a(5, 'h400, ONES, "R8 load at store-only 0x400 reads ones");
    acc_a(1, adr_a(5, 1, 'hF00));
    ld_a(5, 'h800, 0, "R8 store to 0xF00 no effect");

    // R9 level source 7, edge source 5 ignores its line
    exp_ntf_a(7, "R9 rising line notifies");
    @(negedge clk); lvl_a[7] = 1'b1; idle(3);
    ld_a(7, 'h800, 2, "R9 level source pending");
    @(negedge clk); lvl_a[5] = 1'b1; idle(3);
    ld_a(5, 'h800, 0, "R9 edge source ignores level_in");
    lvl_a[5] = 1'b0;

    // R10 EOI with line still high re-notifies
    exp_ntf_a(7, "R10 level re-notify");
    ld_a(7, 'h000, 2, "R10 EOI returns 10");
    ld_a(7, 'h800, 2, "R10 stays 10 while asserted");
    @(negedge clk); lvl_a[7] = 1'b0; idle(3);
    ld_a(7, 'h800, 2, "R9 deassert keeps state");
    ld_a(7, 'h000, 2, "R10 EOI after deassert");
    ld_a(7, 'h800, 0, "R10 back to 00 without notify");

    // R7 one-page layout, R5 store-EOI disabled
    exp_ntf_b(2, "R7 store at offset 0 triggers");
    acc_b(1, 15'((2 << 12) | 'h000));
    ld_b(2, 'h800, 2, "R7 get in same page");
    acc_b(1, 15'((2 << 12) | 'h400));
    ld_b(2, 'h800, 2, "R5 store-EOI ignored when disabled");
    ld_b(2, 'h000, 2, "R7 load-EOI in same page");
    ld_b(2, 'h800, 0, "R7 state 00 after EOI");
    ld_b(1, 'h900, ONES, "R8 1p unrecognised offset");

    finish_run();
  end
endmodule